// File: doc/BRIEF.md
# Logic Analyzer Trigger Capture Engine

This block is the on-chip capture core of an embedded logic analyzer. Every sample clock it looks at a bus of probe lanes and compares each lane with its own programmed value. The enabled compare hits are reduced into one global condition, using AND, OR, NAND or NOR. Each rising edge of that condition is one trigger occurrence. When the programmed number of occurrences has been seen, the engine writes a full window of samples into an internal RAM and then reports that it is done. A host agent reads the window back through a read-address port.

Each lane has a role. A lane can feed both the trigger and the stored data, the stored data only, or the trigger only. Trigger-only lanes are stored as zeros. A level trigger input from a neighbouring instance or an external instrument is acknowledged with a one-cycle pulse. That input can also count as an occurrence. A trigger output is raised either by the local capture start or by the incoming trigger, and it is held until the receiver acknowledges it. Configuration arrives through a small synchronous write port in the sample clock domain. Any serial transport in front of that port is assumed to have already moved it into the sample clock domain.

Top module: `la_capture_engine`

## Requirements
- R1: After reset, `status` is 0 (idle), and `rd_data`, `trig_out` and `trig_in_ack` are all low. The occurrence target resets to 1. Every probe lane resets to role 0 with its trigger disabled.
- R2: The engine arms on a write to address 0 with bit 0 set. On the next edge `status` becomes 1 (armed), from any state. Arming clears the occurrence count and the write pointer, so a run that was already partly counted starts again from zero.
- R3: An occurrence is a rising edge of the global condition seen while `status` is 1 or 2. A condition that stays high counts once. A condition that is already high when the engine arms does not count until it has fallen and risen again.
- R4: The occurrence target is held at address 1, and a value of 0 acts as 1. The edge with the first occurrence moves the engine to `status` 2 (counting). The edge on which the count reaches the target moves it to `status` 3 (capturing). The first stored sample is the probe bus on the next edge.
- R5: Bits 2:1 at address 0 select how the enabled lanes are reduced: 0 = AND, 1 = OR, 2 = NAND, 3 = NOR. A lane's hit is true when the lane equals its compare value.
- R6: Lane i is configured at address 2+i. Bits PW-1:0 hold the compare value, bits PW+1:PW hold the role and bit PW+2 is the trigger enable. Role 1 (data only) never affects the condition. Role 2 (trigger only) is stored as zero. Roles 0 and 3 both trigger and store.
- R7: In the capture state one sample is written per cycle, to addresses 0 up to DEPTH-1. After the last write `status` becomes 4 (done) and stays there until the next arm.
- R8: `rd_data` shows the buffer word at `rd_addr` one cycle after the address is presented, but only while `status` is 4. In every other state it reads zero.
- R9: Each rising edge of `trig_in` gives exactly one high cycle of `trig_in_ack`, on the next edge. When bit 4 at address 0 is set, that rising edge also counts as an occurrence.
- R10: Bit 3 at address 0 selects the source of `trig_out`: 0 = the local capture start, 1 = a rising edge of `trig_in`. The selected event raises `trig_out` on its edge. `trig_out` stays high while `trig_out_ack` is low, and falls on the edge after `trig_out_ack` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| probe_bus | input | NPROBE*PW | Probe lanes, lane i at bits i*PW upward |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | clog2(NPROBE+2) | Configuration register address |
| cfg_wdata | input | max(PW+3,CNTW) | Configuration write data |
| rd_addr | input | clog2(DEPTH) | Buffer read address |
| rd_data | output | NPROBE*PW | Buffer read data, zero outside done |
| status | output | 3 | Engine state: 0 idle, 1 armed, 2 counting, 3 capturing, 4 done |
| trig_in | input | 1 | Cascade trigger input (level) |
| trig_in_ack | output | 1 | One-cycle acknowledge per input trigger |
| trig_out | output | 1 | Cascade trigger output |
| trig_out_ack | input | 1 | Acknowledge for the trigger output |

## Verification
The bench builds the engine with three probe lanes of 8 bits each, an 8-entry buffer and a 4-bit occurrence counter. Three lanes give one lane for each role in a single capture, so one readback shows a data-only lane kept whole and a trigger-only lane zeroed. The 8-entry depth keeps every fill short, so each scenario can run to done and read the whole window back. The 4-bit counter allows a target of 3, which is enough to show that a held condition counts once and that arming in the middle of a count throws the partial count away.

// File: rtl/la_cap_pkg.sv
// Shared types for the capture engine: state encoding, reduction
// operators, lane roles and control-word bit positions.
package la_cap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARMED   = 3'd1,
        ST_COUNT   = 3'd2,
        ST_CAPTURE = 3'd3,
        ST_DONE    = 3'd4
    } cap_state_t;

    typedef enum logic [1:0] {
        RED_AND  = 2'd0,
        RED_OR   = 2'd1,
        RED_NAND = 2'd2,
        RED_NOR  = 2'd3
    } red_op_t;

    localparam logic [1:0] ROLE_BOTH = 2'd0;
    localparam logic [1:0] ROLE_DATA = 2'd1;
    localparam logic [1:0] ROLE_TRIG = 2'd2;

    localparam int CTRL_ARM   = 0;
    localparam int CTRL_OP_LO = 1;
    localparam int CTRL_SRC   = 3;
    localparam int CTRL_EXT   = 4;
endpackage

// File: rtl/la_probe_eval.sv
// Per-lane compare and global reduction.
// Assumes: the configuration inputs are stable registers.
// Produces the combined trigger condition, and the sample word with
// trigger-only lanes forced to zero.
module la_probe_eval
    import la_cap_pkg::*;
#(
    parameter int NPROBE = 4,
    parameter int PW     = 8,
    localparam int SW    = NPROBE * PW
) (
    input  logic [SW-1:0]       probe_bus,
    input  logic [SW-1:0]       cmp_val,
    input  logic [NPROBE-1:0]   trig_en,
    input  logic [2*NPROBE-1:0] role,
    input  red_op_t             op,
    output logic                cond,
    output logic [SW-1:0]       sample
);
    logic [NPROBE-1:0] hit;
    logic [NPROBE-1:0] use_t;

    for (genvar i = 0; i < NPROBE; i++) begin : g_lane
        assign hit[i]   = (probe_bus[i*PW +: PW] == cmp_val[i*PW +: PW]);
        assign use_t[i] = trig_en[i] && (role[2*i +: 2] != ROLE_DATA);
        assign sample[i*PW +: PW] = (role[2*i +: 2] == ROLE_TRIG) ? '0 : probe_bus[i*PW +: PW];
    end

    logic all_ok, any_ok;

    // Reduce the enabled lane hits with the selected operator.
    always_comb begin
        all_ok = &(hit | ~use_t);
        any_ok = |(hit & use_t);
        unique case (op)
            RED_AND:  cond = all_ok;
            RED_OR:   cond = any_ok;
            RED_NAND: cond = ~all_ok;
            default:  cond = ~any_ok;
        endcase
    end
endmodule

// File: rtl/la_trig_link.sv
// Cascade trigger handshakes.
// Assumes: trig_in is already synchronous to clk.
// Pulses an acknowledge for each rising edge of trig_in. Holds trig_out
// from the selected event until the receiver acknowledges it.
module la_trig_link (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic trig_out_ack,
    input  logic from_input,
    input  logic local_fire,
    output logic tin_rise,
    output logic trig_in_ack,
    output logic trig_out
);
    logic tin_q;
    logic out_evt;

    assign tin_rise = trig_in & ~tin_q;
    assign out_evt  = from_input ? tin_rise : local_fire;

    // Track the input level and acknowledge each new edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tin_q       <= 1'b0;
            trig_in_ack <= 1'b0;
        end else begin
            tin_q       <= trig_in;
            trig_in_ack <= tin_rise;
        end
    end

    // Raise the output on an event and drop it once it is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)                      trig_out <= 1'b0;
        else if (trig_out && trig_out_ack) trig_out <= 1'b0;
        else if (out_evt)                trig_out <= 1'b1;
    end

    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_in_ack |=> !trig_in_ack);
    assert_ack_follows_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_in && !tin_q) |=> trig_in_ack);
    assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && !trig_out_ack) |=> trig_out);
    assert_out_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && trig_out_ack) |=> !trig_out);
endmodule

// File: rtl/la_sample_buf.sv
// Sample RAM with one write port and a registered read port.
// Assumes: DEPTH is a power of two. Words are read only after a full fill.
// The read port returns zero unless rd_en (the done state) is high.
module la_sample_buf #(
    parameter int SW    = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [SW-1:0] wdata,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [SW-1:0] rd_data
);
    logic [SW-1:0] mem [DEPTH];

    // Store one sample per write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered readback, gated by the done state.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_addr];
        else            rd_data <= '0;
    end

    assert_rd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));
endmodule

// File: rtl/la_capture_engine.sv
// Top of the trigger and capture engine.
// Assumes: the configuration port is synchronous to the sample clock, and
// DEPTH is a power of two.
// Holds the configuration, counts occurrences, sequences
// idle/armed/counting/capturing/done, and fills the sample buffer.
module la_capture_engine
    import la_cap_pkg::*;
#(
    parameter int NPROBE = 4,
    parameter int PW     = 8,
    parameter int DEPTH  = 16,
    parameter int CNTW   = 8,
    localparam int SW    = NPROBE * PW,
    localparam int AW    = $clog2(DEPTH),
    localparam int CAW   = $clog2(NPROBE + 2),
    localparam int CW    = (PW + 3 > CNTW) ? PW + 3 : CNTW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SW-1:0]  probe_bus,
    input  logic           cfg_we,
    input  logic [CAW-1:0] cfg_addr,
    input  logic [CW-1:0]  cfg_wdata,
    input  logic [AW-1:0]  rd_addr,
    output logic [SW-1:0]  rd_data,
    output logic [2:0]     status,
    input  logic           trig_in,
    output logic           trig_in_ack,
    output logic           trig_out,
    input  logic           trig_out_ack
);
    cap_state_t          state;
    red_op_t             op;
    logic                out_src, ext_en;
    logic [CNTW-1:0]     target, cnt;
    logic [SW-1:0]       cmp_val;
    logic [NPROBE-1:0]   trig_en;
    logic [2*NPROBE-1:0] role;
    logic [AW-1:0]       wptr;
    logic                cond, cond_q, tin_rise, occ_evt, fire, arm;
    logic [SW-1:0]       sample;
    logic [CNTW:0]       eff_target, cnt_next;

    assign arm        = cfg_we && (cfg_addr == '0) && cfg_wdata[CTRL_ARM];
    assign eff_target = (target == '0) ? (CNTW+1)'(1) : {1'b0, target};
    assign cnt_next   = {1'b0, cnt} + (CNTW+1)'(1);
    assign occ_evt    = (cond && !cond_q) || (ext_en && tin_rise);
    assign fire       = occ_evt && (((state == ST_ARMED) && (eff_target == (CNTW+1)'(1))) ||
                                    ((state == ST_COUNT) && (cnt_next >= eff_target)));
    assign status     = state;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op      <= RED_AND;
            out_src <= 1'b0;
            ext_en  <= 1'b0;
            target  <= CNTW'(1);
            cmp_val <= '0;
            trig_en <= '0;
            role    <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == '0) begin
                op      <= red_op_t'(cfg_wdata[CTRL_OP_LO +: 2]);
                out_src <= cfg_wdata[CTRL_SRC];
                ext_en  <= cfg_wdata[CTRL_EXT];
            end
            if (cfg_addr == CAW'(1)) target <= cfg_wdata[CNTW-1:0];
            for (int i = 0; i < NPROBE; i++) begin
                if (cfg_addr == CAW'(i + 2)) begin
                    cmp_val[i*PW +: PW] <= cfg_wdata[PW-1:0];
                    role[2*i +: 2]      <= cfg_wdata[PW +: 2];
                    trig_en[i]          <= cfg_wdata[PW+2];
                end
            end
        end
    end

    // Previous condition level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond;
    end

    // Capture sequencer with the occurrence counter and write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            wptr  <= '0;
        end else if (arm) begin
            state <= ST_ARMED;
            cnt   <= '0;
            wptr  <= '0;
        end else begin
            unique case (state)
                ST_ARMED, ST_COUNT: begin
                    if (fire)         state <= ST_CAPTURE;
                    else if (occ_evt) begin
                        state <= ST_COUNT;
                        cnt   <= cnt_next[CNTW-1:0];
                    end
                end
                ST_CAPTURE: begin
                    if (wptr == AW'(DEPTH - 1)) state <= ST_DONE;
                    wptr <= wptr + AW'(1);
                end
                default: ;
            endcase
        end
    end

    la_probe_eval #(.NPROBE(NPROBE), .PW(PW)) u_eval (
        .probe_bus(probe_bus), .cmp_val(cmp_val), .trig_en(trig_en),
        .role(role), .op(op), .cond(cond), .sample(sample)
    );

    la_trig_link u_link (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_out_ack(trig_out_ack),
        .from_input(out_src), .local_fire(fire), .tin_rise(tin_rise),
        .trig_in_ack(trig_in_ack), .trig_out(trig_out)
    );

    la_sample_buf #(.SW(SW), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(state == ST_CAPTURE), .waddr(wptr),
        .wdata(sample), .rd_en(state == ST_DONE), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (state == ST_ARMED));
    assert_wait_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ARMED || state == ST_COUNT) && !occ_evt && !arm) |=> $stable(state));
    assert_count_below_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |-> ({1'b0, cnt} < eff_target));
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !arm) |=> (state == ST_DONE));
endmodule

// File: tb/sim_la_capture_engine.sv
// Directed bench for the capture engine. Each task runs one scenario and
// checks its own results. Inputs change and outputs are sampled on the
// falling clock edge.
module sim_la_capture_engine;
    localparam int NPROBE = 3, PW = 8, DEPTH = 8, CNTW = 4;
    localparam int SW = NPROBE * PW, AW = $clog2(DEPTH), CAW = $clog2(NPROBE + 2), CW = PW + 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [SW-1:0]  probe_bus = '0;
    logic           cfg_we = 1'b0;
    logic [CAW-1:0] cfg_addr = '0;
    logic [CW-1:0]  cfg_wdata = '0;
    logic [AW-1:0]  rd_addr = '0;
    logic [SW-1:0]  rd_data;
    logic [2:0]     status;
    logic           trig_in = 1'b0, trig_in_ack, trig_out, trig_out_ack = 1'b1;

    int n_chk = 0, n_fail = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    la_capture_engine #(.NPROBE(NPROBE), .PW(PW), .DEPTH(DEPTH), .CNTW(CNTW)) u0 (
        .clk(clk), .rst_n(rst_n), .probe_bus(probe_bus), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_addr(rd_addr),
        .rd_data(rd_data), .status(status), .trig_in(trig_in),
        .trig_in_ack(trig_in_ack), .trig_out(trig_out), .trig_out_ack(trig_out_ack)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic wr(input int addr, input int data);
        cfg_we = 1'b1; cfg_addr = CAW'(addr); cfg_wdata = CW'(data);
        step();
        cfg_we = 1'b0;
    endtask

    // Lane word: {enable, role, compare value}
    function automatic int lane(input bit en, input int rl, input int val);
        return (int'(en) << (PW + 2)) | (rl << PW) | val;
    endfunction

    // Control word: {ext_en, out_src, op, arm}
    function automatic int ctl(input bit ext, input bit src, input int op);
        return (int'(ext) << 4) | (int'(src) << 3) | (op << 1) | 1;
    endfunction

    function automatic logic [SW-1:0] pat(input int j);
        return {8'(8'h80 + j), 8'(8'h40 + j), 8'(j)};
    endfunction

    function automatic logic [SW-1:0] lanes(input int p2, input int p1, input int p0);
        return {8'(p2), 8'(p1), 8'(p0)};
    endfunction

    // Run DEPTH capture cycles and confirm the done state (R7).
    task automatic fill_and_done(input string tag);
        for (int j = 0; j < DEPTH; j++) begin
            probe_bus = pat(j);
            step();
        end
        chk({tag, " R7 done after fill"}, 64'(status), 64'd4);
    endtask

    task automatic t_reset();
        chk("R1 status idle", 64'(status), 64'd0);
        chk("R1 trig_out low", 64'(trig_out), 64'd0);
        chk("R1 trig_in_ack low", 64'(trig_in_ack), 64'd0);
        chk("R1 rd_data zero", 64'(rd_data), 64'd0);
    endtask

    // Target 1, AND; data-only lane ignored for the trigger, trigger-only lane zeroed.
    task automatic t_basic_capture();
        wr(2, lane(1, 0, 8'h5A));
        wr(3, lane(1, 1, 8'hFF));
        wr(4, lane(0, 2, 0));
        probe_bus = '0;
        trig_out_ack = 1'b0;
        wr(0, ctl(0, 0, 0));
        chk("R2 armed", 64'(status), 64'd1);
        probe_bus = lanes(0, 0, 8'h5A);
        step();
        chk("R4 R6 capture on first hit", 64'(status), 64'd3);
        chk("R10 trig_out raised by local fire", 64'(trig_out), 64'd1);
        rd_addr = '0;
        for (int j = 0; j < DEPTH; j++) begin
            probe_bus = pat(j);
            step();
            if (j == 0) chk("R8 zero read while capturing", 64'(rd_data), 64'd0);
        end
        chk("R7 done", 64'(status), 64'd4);
        chk("R10 trig_out held without ack", 64'(trig_out), 64'd1);
        trig_out_ack = 1'b1;
        step();
        chk("R10 trig_out released after ack", 64'(trig_out), 64'd0);
        for (int j = 0; j < DEPTH; j++) begin
            rd_addr = AW'(j);
            step();
            chk($sformatf("R6 R8 readback %0d", j), 64'(rd_data), 64'({8'h00, pat(j)[15:0]}));
        end
        for (int j = 0; j < 3; j++) begin
            probe_bus = (j % 2 == 1) ? lanes(0, 0, 8'h5A) : '0;
            step();
        end
        chk("R7 done holds without arm", 64'(status), 64'd4);
    endtask

    // Target 3, OR; a held condition counts once; high-at-arm does not count.
    task automatic t_occurrences();
        wr(2, lane(1, 0, 8'h33));
        wr(3, lane(0, 0, 0));
        wr(4, lane(0, 0, 0));
        wr(1, 3);
        probe_bus = lanes(0, 0, 8'h33);
        wr(0, ctl(0, 0, 1));
        step(); step();
        chk("R3 high at arm not counted", 64'(status), 64'd1);
        probe_bus = '0; step();
        probe_bus = lanes(0, 0, 8'h33); step();
        chk("R3 R4 first occurrence counting", 64'(status), 64'd2);
        step(); step();
        chk("R3 held condition counted once", 64'(status), 64'd2);
        probe_bus = '0; step();
        probe_bus = lanes(0, 0, 8'h33); step();
        chk("R4 second occurrence still counting", 64'(status), 64'd2);
        probe_bus = '0; step();
        probe_bus = lanes(0, 0, 8'h33); step();
        chk("R4 third occurrence captures", 64'(status), 64'd3);
        fill_and_done("occ");
    endtask

    // AND needs all enabled lanes; NOR and NAND fire on the inverse.
    task automatic t_reductions();
        wr(1, 1);
        wr(2, lane(1, 0, 8'h11));
        wr(4, lane(1, 3, 8'h22));
        probe_bus = lanes(0, 0, 8'h11);
        wr(0, ctl(0, 0, 0));
        step();
        chk("R5 AND waits for all lanes", 64'(status), 64'd1);
        probe_bus = lanes(8'h22, 0, 8'h11); step();
        chk("R5 AND fires", 64'(status), 64'd3);
        fill_and_done("and");

        wr(4, lane(0, 0, 0));
        probe_bus = lanes(0, 0, 8'h11);
        wr(0, ctl(0, 0, 3));
        step();
        chk("R5 NOR low while lane hits", 64'(status), 64'd1);
        probe_bus = '0; step();
        chk("R5 NOR fires on miss", 64'(status), 64'd3);
        fill_and_done("nor");

        wr(4, lane(1, 0, 8'h22));
        probe_bus = lanes(8'h22, 0, 8'h11);
        wr(0, ctl(0, 0, 2));
        step();
        chk("R5 NAND low while all hit", 64'(status), 64'd1);
        probe_bus = lanes(0, 0, 8'h11); step();
        chk("R5 NAND fires on one miss", 64'(status), 64'd3);
        fill_and_done("nand");
    endtask

    // Incoming trigger counts, is acknowledged once, and is forwarded.
    task automatic t_cascade();
        wr(2, lane(0, 0, 0));
        wr(4, lane(0, 0, 0));
        probe_bus = '0;
        trig_out_ack = 1'b0;
        wr(0, ctl(1, 1, 1));
        chk("R9 armed before input", 64'(status), 64'd1);
        trig_in = 1'b1; step();
        chk("R9 ack pulse", 64'(trig_in_ack), 64'd1);
        chk("R9 input trigger captures", 64'(status), 64'd3);
        chk("R10 forwarded to trig_out", 64'(trig_out), 64'd1);
        step();
        chk("R9 ack lasts one cycle", 64'(trig_in_ack), 64'd0);
        chk("R10 held while ack low", 64'(trig_out), 64'd1);
        trig_out_ack = 1'b1; step();
        chk("R10 dropped after ack", 64'(trig_out), 64'd0);
        trig_in = 1'b0;
        for (int j = 0; j < DEPTH; j++) step();
        chk("R7 cascade done", 64'(status), 64'd4);
    endtask

    // Arming in the middle of a count discards the partial count.
    task automatic t_rearm();
        wr(1, 2);
        wr(2, lane(1, 0, 8'h33));
        probe_bus = '0;
        wr(0, ctl(0, 0, 1));
        step();
        chk("R8 zero read after re-arm", 64'(rd_data), 64'd0);
        probe_bus = lanes(0, 0, 8'h33); step();
        chk("R2 one occurrence counting", 64'(status), 64'd2);
        probe_bus = '0;
        wr(0, ctl(0, 0, 1));
        chk("R2 re-armed from counting", 64'(status), 64'd1);
        probe_bus = lanes(0, 0, 8'h33); step();
        chk("R2 count restarted", 64'(status), 64'd2);
        probe_bus = '0; step();
        probe_bus = lanes(0, 0, 8'h33); step();
        chk("R2 second occurrence captures", 64'(status), 64'd3);
        fill_and_done("rearm");
    endtask

    initial begin
        #(20 * 200000);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic_capture();
        t_occurrences();
        t_reductions();
        t_cascade();
        t_rearm();
        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule